// File: doc/BRIEF.md
# Four-Bank Word Memory with Enabled Bank Decoder

This block is a tiny memory made of four identical banks, each storing four words of four bits. Two bank-select bits pass through an enabled 2-to-4 decoder. The decoder produces active-low chip selects, so at most one bank responds to the shared read and write strobes. The word address and both strobes reach every bank in parallel.

Write data does not go straight to the banks. It is first staged in an input register that loads whenever its store enable is high at a clock edge, and that register feeds every bank. The bank outputs are merged by a two-level bitwise OR tree, not a multiplexer. For this reason a bank that is not selected, or not being read, drives zero. The merged value is loaded into an output register on edges where the output store enable is high.

Top module: `banked_mem`

## Requirements
- R1: After a synchronous active-low reset, every word of every bank, the staged write register and the output register all hold 0.
- R2: The staged write register loads `wr_data_i` on a rising edge when `stage_ld_i` is 1 and otherwise keeps its value. Every bank write takes its data from this register.
- R3: With `dec_en_i` high, the bank index is `{bank_sel_hi_i, bank_sel_lo_i}`. The high bit is the most significant, and index 0..3 picks bank 0..3.
- R4: With `dec_en_i` low, no bank is written and the merged read value is 0000.
- R5: A write stores the staged data into the selected bank at `word_addr_i` on the rising edge when `wr_i` is 1 and the decoder is enabled. The other banks and the other words are left unchanged.
- R6: With `rd_i` low, the merged read value is 0000.
- R7: The merged read value is the selected bank's word at `word_addr_i`, combinational from the address. It is the bitwise OR of all bank outputs, and every unselected bank drives zero.
- R8: `rd_data_o` loads the merged read value on a rising edge when `cap_ld_i` is 1 and otherwise keeps its value.
- R9: When `rd_i` and `wr_i` are both high in the same cycle, the write is performed and the merged read value in that cycle is the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous active-low reset |
| stage_ld_i | input | 1 | Load enable of the write-data register |
| cap_ld_i | input | 1 | Load enable of the read-data register |
| bank_sel_hi_i | input | 1 | Bank select, most significant bit |
| bank_sel_lo_i | input | 1 | Bank select, least significant bit |
| dec_en_i | input | 1 | Decoder enable |
| word_addr_i | input | 2 | Word address shared by all banks |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wr_data_i | input | 4 | Data into the staging register |
| rd_data_o | output | 4 | Output register contents |

## Verification
The bench writes distinct patterns into all sixteen locations and reads each one back, so a swapped select-bit order or an inverted chip select shows up as data landing in the wrong bank. A write issued with the decoder disabled must leave every bank unchanged. A read with the strobe or the enable low must capture zero; a bank that leaks its contents would instead pollute the OR merge. The bench also covers a cycle where read and write are both high, which must return the old word, and a write made without restaging, which must reuse the held staged value.

// File: rtl/banked_mem_pkg.sv
// Package: shared widths for the banked memory.
// Assumes: a power-of-two bank count.
package banked_mem_pkg;
    parameter int unsigned DATA_W  = 4;
    parameter int unsigned WORDS   = 4;
    parameter int unsigned BANKS   = 4;
    localparam int unsigned ADDR_W = $clog2(WORDS);
    localparam int unsigned SEL_W  = $clog2(BANKS);
    typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/bank_decoder.sv
// Module: bank_decoder
// Turns a select index into active-low chip selects, one per bank.
// Each output is a NAND of the enable with true or complemented select bits.
// Assumes: sel_i bit SEL_W-1 is the most significant select bit.
module bank_decoder #(
    parameter int unsigned BANKS = 4,
    localparam int unsigned SEL_W = $clog2(BANKS)
) (
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [BANKS-1:0] cs_no
);
    for (genvar b = 0; b < BANKS; b++) begin : g_term
        logic [SEL_W-1:0] lit;
        for (genvar k = 0; k < SEL_W; k++) begin : g_lit
            // Pick the true or complemented literal for bit k of index b.
            assign lit[k] = ((b >> k) & 1) ? sel_i[k] : ~sel_i[k];
        end
        // NAND of the enable with every literal of this term.
        assign cs_no[b] = ~(en_i & (&lit));
    end
endmodule

// File: rtl/mem_bank.sv
// Module: mem_bank
// A small register-file bank with an active-low chip select.
// It drives zero unless it is both selected and read, so it can feed an OR tree.
// Assumes: synchronous active-low reset clears every word.
module mem_bank #(
    parameter int unsigned DATA_W = 4,
    parameter int unsigned WORDS  = 4,
    localparam int unsigned ADDR_W = $clog2(WORDS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cs_ni,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dout_o
);
    logic [DATA_W-1:0] store_q [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        // Clear this word on reset; load it on a selected write to its address.
        always_ff @(posedge clk_i) begin
            if (!rst_ni)
                store_q[w] <= '0;
            else if (!cs_ni && wr_i && (addr_i == ADDR_W'(w)))
                store_q[w] <= din_i;
        end
    end

    // Drive the addressed word only while selected and read, else zero.
    always_comb begin
        dout_o = (!cs_ni && rd_i) ? store_q[addr_i] : '0;
    end
endmodule

// File: rtl/or_merge.sv
// Module: or_merge
// Bitwise OR reduction of BANKS words, built as a pairwise tree.
// Assumes: BANKS is a power of two; unused inputs are zero.
module or_merge #(
    parameter int unsigned BANKS  = 4,
    parameter int unsigned DATA_W = 4,
    localparam int unsigned LVLS  = $clog2(BANKS)
) (
    input  logic [BANKS-1:0][DATA_W-1:0] in_i,
    output logic [DATA_W-1:0]            out_o
);
    logic [LVLS:0][BANKS-1:0][DATA_W-1:0] node;
    assign node[0] = in_i;
    for (genvar l = 0; l < LVLS; l++) begin : g_lvl
        for (genvar n = 0; n < BANKS; n++) begin : g_node
            if (n < (BANKS >> (l + 1))) begin : g_or
                // Combine neighbouring pair 2n, 2n+1 of the level below.
                assign node[l+1][n] = node[l][2*n] | node[l][2*n+1];
            end else begin : g_pad
                assign node[l+1][n] = '0;
            end
        end
    end
    assign out_o = node[LVLS][0];
endmodule

// File: rtl/banked_mem.sv
// Module: banked_mem (top)
// Four-bank memory: a staged write register, an enabled active-low decoder,
// shared strobes and address, an OR-tree read merge and a capture register.
// Assumes: single clock, synchronous active-low reset.
module banked_mem
    import banked_mem_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              stage_ld_i,
    input  logic              cap_ld_i,
    input  logic              bank_sel_hi_i,
    input  logic              bank_sel_lo_i,
    input  logic              dec_en_i,
    input  logic [ADDR_W-1:0] word_addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o
);
    word_t                          stage_q;
    word_t                          merged;
    logic [BANKS-1:0]               cs_n;
    logic [BANKS-1:0][DATA_W-1:0]   bank_out;

    // Stage write data when the store enable is high.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)         stage_q <= '0;
        else if (stage_ld_i) stage_q <= wr_data_i;
    end

    bank_decoder #(.BANKS(BANKS)) u_dec (
        .en_i  (dec_en_i),
        .sel_i ({bank_sel_hi_i, bank_sel_lo_i}),
        .cs_no (cs_n)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        mem_bank #(.DATA_W(DATA_W), .WORDS(WORDS)) u_bank (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .cs_ni  (cs_n[b]),
            .rd_i   (rd_i),
            .wr_i   (wr_i),
            .addr_i (word_addr_i),
            .din_i  (stage_q),
            .dout_o (bank_out[b])
        );
    end

    or_merge #(.BANKS(BANKS), .DATA_W(DATA_W)) u_merge (
        .in_i  (bank_out),
        .out_o (merged)
    );

    // Capture the merged read value when the output store enable is high.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)       rd_data_o <= '0;
        else if (cap_ld_i) rd_data_o <= merged;
    end
endmodule

// File: rtl/banked_mem_chk.sv
// Module: banked_mem_chk
// Protocol checks on the memory, attached by bind.
// Assumes: it sees the top's ports and its internal merge and chip selects.
module banked_mem_chk
    import banked_mem_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cap_ld_i,
    input  logic              dec_en_i,
    input  logic              rd_i,
    input  logic [BANKS-1:0]  cs_n,
    input  word_t             merged,
    input  word_t             rd_data_o
);
    AST_CS_ONE_HOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(~cs_n) <= 1); // R3
    AST_DISABLED_NO_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dec_en_i |-> (&cs_n)); // R4
    AST_DISABLED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dec_en_i |-> (merged == '0)); // R4
    AST_NO_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_i |-> (merged == '0)); // R6
    AST_CAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cap_ld_i && $past(rst_ni)) |=> $stable(rd_data_o)); // R8
endmodule

bind banked_mem banked_mem_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_ld_i  (cap_ld_i),
    .dec_en_i  (dec_en_i),
    .rd_i      (rd_i),
    .cs_n      (cs_n),
    .merged    (merged),
    .rd_data_o (rd_data_o)
);

// File: tb/sim_banked_mem.sv
module sim_banked_mem;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       stage_ld = 0, cap_ld = 0, sel_hi = 0, sel_lo = 0, en = 0;
    logic [1:0] addr = 0;
    logic       rd = 0, wr = 0;
    logic [3:0] din = 0;
    logic [3:0] dout;
    logic [3:0] ref_m [4][4];
    int         n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    banked_mem u0 (
        .clk_i(clk), .rst_ni(rst_n), .stage_ld_i(stage_ld), .cap_ld_i(cap_ld),
        .bank_sel_hi_i(sel_hi), .bank_sel_lo_i(sel_lo), .dec_en_i(en),
        .word_addr_i(addr), .rd_i(rd), .wr_i(wr), .wr_data_i(din),
        .rd_data_o(dout)
    );

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    function automatic logic [3:0] exp_read(input logic e, input logic r,
                                            input int b, input int a);
        return (e && r) ? ref_m[b][a] : 4'h0;
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        stage_ld = 0; cap_ld = 0; rd = 0; wr = 0;
    endtask

    // Stage data (one edge), then write it into bank b, word a.
    task automatic do_write(input int b, input int a, input logic [3:0] d, input logic e);
        @(negedge clk); idle(); din = d; stage_ld = 1;
        @(negedge clk); idle();
        {sel_hi, sel_lo} = 2'(b); addr = 2'(a); en = e; wr = 1;
        @(negedge clk); idle();
        if (e) ref_m[b][a] = d;
    endtask

    // Read bank b, word a through the capture register.
    task automatic do_read(input int b, input int a, input logic e, input logic r,
                           input string req);
        @(negedge clk); idle();
        {sel_hi, sel_lo} = 2'(b); addr = 2'(a); en = e; rd = r; cap_ld = 1;
        @(negedge clk); idle();
        check(req, dout, exp_read(e, r, b, a));
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int b = 0; b < 4; b++) for (int a = 0; a < 4; a++) ref_m[b][a] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("R1 reset output", dout, 4'h0);
        for (int b = 0; b < 4; b++) for (int a = 0; a < 4; a++) do_read(b, a, 1, 1, "R1 reset contents");

        // R3 R5 R7: distinct pattern per location
        for (int b = 0; b < 4; b++) for (int a = 0; a < 4; a++)
            do_write(b, a, 4'((b * 4 + a) ^ 4'h9), 1);
        for (int b = 0; b < 4; b++) for (int a = 0; a < 4; a++) do_read(b, a, 1, 1, "R3 R5 R7 sweep");

        // R4: disabled write has no effect, disabled read is zero
        do_write(2, 1, 4'hF, 0);
        for (int b = 0; b < 4; b++) do_read(b, 1, 1, 1, "R4 disabled write");
        do_read(2, 1, 0, 1, "R4 disabled read");
        // R6: read strobe low yields zero
        do_read(3, 3, 1, 0, "R6 no read");

        // R8: capture holds with cap_ld low
        do_read(1, 2, 1, 1, "R8 load");
        @(negedge clk); idle(); {sel_hi, sel_lo} = 2'd3; addr = 0; en = 1; rd = 1;
        @(negedge clk); idle();
        check("R8 hold", dout, ref_m[1][2]);

        // R9: simultaneous read and write returns old word, then new
        @(negedge clk); idle(); din = 4'h6; stage_ld = 1;
        @(negedge clk); idle(); {sel_hi, sel_lo} = 2'd1; addr = 2'd3; en = 1;
        rd = 1; wr = 1; cap_ld = 1;
        @(negedge clk); idle();
        check("R9 old data", dout, ref_m[1][3]);
        ref_m[1][3] = 4'h6;
        do_read(1, 3, 1, 1, "R9 new data");

        // R2: write without restaging reuses held staged value
        @(negedge clk); idle(); din = 4'hA;
        {sel_hi, sel_lo} = 2'd0; addr = 2'd2; en = 1; wr = 1;
        @(negedge clk); idle();
        ref_m[0][2] = 4'h6;
        do_read(0, 2, 1, 1, "R2 held stage");

        // Random mix
        for (int i = 0; i < 200; i++) begin
            int b = int'($urandom_range(0, 3));
            int a = int'($urandom_range(0, 3));
            if ($urandom_range(0, 1) != 0)
                do_write(b, a, 4'($urandom_range(0, 15)), logic'($urandom_range(0, 3) != 0));
            else
                do_read(b, a, logic'($urandom_range(0, 3) != 0), logic'($urandom_range(0, 3) != 0),
                        "R7 random");
        end
        for (int b = 0; b < 4; b++) for (int a = 0; a < 4; a++) do_read(b, a, 1, 1, "R5 final sweep");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule